// File: doc/BRIEF.md
# Two-Port Word Memory with Collision Write Guard

This block is a synchronous model of a 2048-word by 8-bit memory with two independent ports, left and right. Each port has its own enable, write select, output enable, address, write data and registered read data with a valid flag. Both ports may touch any word in the same clock cycle. When the two ports name the same word, one of them is marked busy. A busy port keeps reading, but its writes are thrown away.

A mode input picks where the busy indication comes from. In master mode an on-chip address comparator decides the loser and shows the result on active-low busy outputs. In slave mode the comparator is idle and the busy outputs are held high. Writes are then guarded by active-low busy inputs, which a master copy of the block drives when several copies are placed side by side to widen the data path.

Top module: `dual_port_guarded_ram`

## Requirements
- R1: The store holds 2048 words of 8 bits. Each port has its own 11-bit address, and accesses by the two ports to different words in the same cycle do not disturb each other.
- R2: A port with en=1 and wr=1 whose effective busy is high stores its wdata at its addr at the clock edge. A later read from either port returns that value.
- R3: A port with en=1, wr=0 and oe=1 at a clock edge presents the stored word on rdata with rvalid=1 after that edge (one cycle of latency). In every other case rvalid is 0 and rdata is 0 after that edge.
- R4: A port with en=0 ignores wr, oe, addr and wdata. It writes nothing, reads nothing and takes no part in address matching.
- R5: A write from a port whose effective busy is low is discarded. A read from that port is still carried out.
- R6: In master mode (master_mode=1), when both ports have en=1 and equal addresses, exactly one port's busy_n_out goes low, in the same cycle. The two busy_n_out outputs are never low together.
- R7: Master-mode winner rule. A port that already had en=1 at the same address in the previous cycle wins against a port that did not. When both arrive together, or both were already there, the left port wins. The winner keeps winning for as long as the match lasts in consecutive cycles.
- R8: In slave mode (master_mode=0), both busy_n_out outputs stay high. Each port's effective busy is its busy_n_in input.
- R9: In master mode the busy_n_in inputs have no effect.
- R10: When both ports use the same word in one cycle, with the winner writing and the loser reading, the loser gets the value held before that write.
- R11: In slave mode, if both ports write the same word in one cycle and neither is busy, the left port's data is stored.
- R12: Synchronous active-high reset clears rvalid and rdata on both ports and clears the arbitration history. Stored words are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | 1: internal arbitration drives busy; 0: busy taken from inputs |
| l_en | input | 1 | Left port enable |
| l_wr | input | 1 | Left port write select (1 write, 0 read) |
| l_oe | input | 1 | Left port output enable for reads |
| l_addr | input | 11 | Left port word address |
| l_wdata | input | 8 | Left port write data |
| l_busy_n_in | input | 1 | Left port external busy, active low, used in slave mode |
| l_rdata | output | 8 | Left port registered read data |
| l_rvalid | output | 1 | Left port read data valid |
| l_busy_n_out | output | 1 | Left port busy from the arbiter, active low |
| r_en | input | 1 | Right port enable |
| r_wr | input | 1 | Right port write select (1 write, 0 read) |
| r_oe | input | 1 | Right port output enable for reads |
| r_addr | input | 11 | Right port word address |
| r_wdata | input | 8 | Right port write data |
| r_busy_n_in | input | 1 | Right port external busy, active low, used in slave mode |
| r_rdata | output | 8 | Right port registered read data |
| r_rvalid | output | 1 | Right port read data valid |
| r_busy_n_out | output | 1 | Right port busy from the arbiter, active low |

## Verification
The assertions check on every cycle that the two ports never lose together, that a loss lasts as long as the match does, and that the busy outputs stay high in slave mode. They also check that rvalid follows a read request one cycle later, with rdata at zero when no read was made. Whether a busy write really left the stored word untouched, which value the loser reads in the cycle the winner writes, and which port's data survives a slave-mode double write can only be seen by reading words back. The bench scenarios do that against its own model of the memory.

// File: rtl/dpg_pkg.sv
package dpg_pkg;

    localparam int unsigned ADDR_W = 11;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned DEPTH  = 1 << ADDR_W;
    localparam int unsigned NPORT  = 2;
    localparam int unsigned P_LEFT  = 0;
    localparam int unsigned P_RIGHT = 1;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic  en;
        logic  wr;
        logic  oe;
        addr_t addr;
        word_t wdata;
    } port_req_t;

    typedef struct packed {
        logic  valid;
        word_t data;
    } port_rsp_t;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    function automatic logic wants_write(input port_req_t r);
        return r.en & r.wr;
    endfunction

    function automatic logic wants_read(input port_req_t r);
        return r.en & ~r.wr & r.oe;
    endfunction

    function automatic logic same_spot(input port_req_t a, input port_req_t b);
        return a.en & b.en & (a.addr == b.addr);
    endfunction

endpackage

// File: rtl/dpg_arbiter.sv
module dpg_arbiter
    import dpg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      arb_on,
    input  port_req_t l_req,
    input  port_req_t r_req,
    output logic      l_lose,
    output logic      r_lose
);

    owner_e owner_q, owner_d, winner;
    logic   l_prev_en, r_prev_en;
    addr_t  l_prev_addr, r_prev_addr;
    logic   match, l_settled, r_settled;

    always_comb begin
        match     = arb_on & same_spot(l_req, r_req);
        l_settled = l_prev_en & (l_prev_addr == l_req.addr);
        r_settled = r_prev_en & (r_prev_addr == r_req.addr);
        if (owner_q != OWN_NONE)
            winner = owner_q;
        else if (r_settled && !l_settled)
            winner = OWN_RIGHT;
        else
            winner = OWN_LEFT;
        l_lose  = match & (winner == OWN_RIGHT);
        r_lose  = match & (winner == OWN_LEFT);
        owner_d = match ? winner : OWN_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q     <= OWN_NONE;
            l_prev_en   <= 1'b0;
            r_prev_en   <= 1'b0;
            l_prev_addr <= '0;
            r_prev_addr <= '0;
        end else begin
            owner_q     <= owner_d;
            l_prev_en   <= l_req.en;
            r_prev_en   <= r_req.en;
            l_prev_addr <= l_req.addr;
            r_prev_addr <= r_req.addr;
        end
    end

    a_r6_single_loser: assert property (@(posedge clk) disable iff (rst)
        !(l_lose && r_lose));

    a_r4_loss_needs_both_enabled: assert property (@(posedge clk) disable iff (rst)
        (l_lose || r_lose) |-> (l_req.en && r_req.en));

    a_r7_left_loss_held: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(l_lose) && match) |-> l_lose);

    a_r7_right_loss_held: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(r_lose) && match) |-> r_lose);

endmodule

// File: rtl/dpg_busy_route.sv
module dpg_busy_route
    import dpg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             master_mode,
    input  logic [NPORT-1:0] lose,
    input  logic [NPORT-1:0] ext_busy_n,
    output logic [NPORT-1:0] busy_n_out,
    output logic [NPORT-1:0] eff_busy_n
);

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        always_comb begin
            busy_n_out[p] = master_mode ? ~lose[p] : 1'b1;
            eff_busy_n[p] = master_mode ? ~lose[p] : ext_busy_n[p];
        end

        a_r8_slave_out_high: assert property (@(posedge clk) disable iff (rst)
            !master_mode |-> busy_n_out[p]);
    end

endmodule

// File: rtl/dpg_store.sv
module dpg_store
    import dpg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  port_req_t l_req,
    input  port_req_t r_req,
    input  logic      l_allow,
    input  logic      r_allow,
    output port_rsp_t l_rsp,
    output port_rsp_t r_rsp
);

    word_t     mem [DEPTH];
    port_req_t req_a [NPORT];
    port_rsp_t rsp_a [NPORT];
    logic      l_we, r_we;

    always_comb begin
        req_a[P_LEFT]  = l_req;
        req_a[P_RIGHT] = r_req;
        l_we = wants_write(l_req) & l_allow;
        r_we = wants_write(r_req) & r_allow;
    end

    // Right first, so the left port overrides on a shared word.
    always_ff @(posedge clk) begin
        if (r_we) mem[r_req.addr] <= r_req.wdata;
        if (l_we) mem[l_req.addr] <= l_req.wdata;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_read
        always_ff @(posedge clk) begin
            if (rst) begin
                rsp_a[p] <= '0;
            end else if (wants_read(req_a[p])) begin
                rsp_a[p].valid <= 1'b1;
                rsp_a[p].data  <= mem[req_a[p].addr];
            end else begin
                rsp_a[p] <= '0;
            end
        end

        a_r3_valid_tracks_request: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (rsp_a[p].valid == $past(req_a[p].en && !req_a[p].wr && req_a[p].oe)));

        a_r3_idle_data_zero: assert property (@(posedge clk) disable iff (rst)
            !rsp_a[p].valid |-> (rsp_a[p].data == '0));
    end

    assign l_rsp = rsp_a[P_LEFT];
    assign r_rsp = rsp_a[P_RIGHT];

endmodule

// File: rtl/dual_port_guarded_ram.sv
module dual_port_guarded_ram
    import dpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              master_mode,
    input  logic              l_en,
    input  logic              l_wr,
    input  logic              l_oe,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              l_busy_n_in,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rvalid,
    output logic              l_busy_n_out,
    input  logic              r_en,
    input  logic              r_wr,
    input  logic              r_oe,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    input  logic              r_busy_n_in,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rvalid,
    output logic              r_busy_n_out
);

    port_req_t        l_req, r_req;
    port_rsp_t        l_rsp, r_rsp;
    logic             l_lose, r_lose;
    logic [NPORT-1:0] lose_v, ext_v, out_v, eff_v;

    always_comb begin
        l_req = '{en: l_en, wr: l_wr, oe: l_oe, addr: l_addr, wdata: l_wdata};
        r_req = '{en: r_en, wr: r_wr, oe: r_oe, addr: r_addr, wdata: r_wdata};
        lose_v[P_LEFT]  = l_lose;
        lose_v[P_RIGHT] = r_lose;
        ext_v[P_LEFT]   = l_busy_n_in;
        ext_v[P_RIGHT]  = r_busy_n_in;
    end

    dpg_arbiter u_arb (
        .clk    (clk),
        .rst    (rst),
        .arb_on (master_mode),
        .l_req  (l_req),
        .r_req  (r_req),
        .l_lose (l_lose),
        .r_lose (r_lose)
    );

    dpg_busy_route u_route (
        .clk         (clk),
        .rst         (rst),
        .master_mode (master_mode),
        .lose        (lose_v),
        .ext_busy_n  (ext_v),
        .busy_n_out  (out_v),
        .eff_busy_n  (eff_v)
    );

    dpg_store u_store (
        .clk     (clk),
        .rst     (rst),
        .l_req   (l_req),
        .r_req   (r_req),
        .l_allow (eff_v[P_LEFT]),
        .r_allow (eff_v[P_RIGHT]),
        .l_rsp   (l_rsp),
        .r_rsp   (r_rsp)
    );

    assign l_rdata      = l_rsp.data;
    assign l_rvalid     = l_rsp.valid;
    assign r_rdata      = r_rsp.data;
    assign r_rvalid     = r_rsp.valid;
    assign l_busy_n_out = out_v[P_LEFT];
    assign r_busy_n_out = out_v[P_RIGHT];

    a_r9_master_ignores_inputs: assert property (@(posedge clk) disable iff (rst)
        (master_mode && !(l_en && r_en && l_addr == r_addr)) |-> (l_busy_n_out && r_busy_n_out));

endmodule

// File: tb/dual_port_guarded_ram_tb_top.sv
module dual_port_guarded_ram_tb_top;
    import dpg_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic master_mode = 1'b0;
    logic l_en = 0, l_wr = 0, l_oe = 0, l_busy_n_in = 1;
    logic r_en = 0, r_wr = 0, r_oe = 0, r_busy_n_in = 1;
    addr_t l_addr = '0, r_addr = '0;
    word_t l_wdata = '0, r_wdata = '0;
    word_t l_rdata, r_rdata;
    logic  l_rvalid, r_rvalid, l_busy_n_out, r_busy_n_out;

    always #10 clk = ~clk;

    dual_port_guarded_ram dut_i (
        .clk(clk), .rst(rst), .master_mode(master_mode),
        .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_busy_n_in(l_busy_n_in), .l_rdata(l_rdata), .l_rvalid(l_rvalid),
        .l_busy_n_out(l_busy_n_out),
        .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_busy_n_in(r_busy_n_in), .r_rdata(r_rdata), .r_rvalid(r_rvalid),
        .r_busy_n_out(r_busy_n_out)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    string tag_rd = "R2";
    string tag_bz = "R6";

    // bench model
    word_t  m [DEPTH];
    int     own = 0;          // 0 none, 1 left, 2 right
    bit     ple = 0, pre = 0;
    addr_t  pla = '0, pra = '0;
    bit     exp_lv = 0, exp_rv = 0;
    word_t  exp_ld = '0, exp_rd = '0;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic port_req_t mk(input bit en, input bit wr, input bit oe,
                                     input addr_t a, input word_t d);
        port_req_t q;
        q.en = en; q.wr = wr; q.oe = oe; q.addr = a; q.wdata = d;
        return q;
    endfunction

    task automatic step(input bit mode, input port_req_t lq, input port_req_t rq,
                        input bit lbi, input bit rbi);
        bit match, ls, rs, lbn, rbn, leff, reff;
        int win;
        @(negedge clk);
        chk(l_rvalid, exp_lv, {tag_rd, " left rvalid (R3)"});
        chk(l_rdata,  exp_ld, {tag_rd, " left rdata"});
        chk(r_rvalid, exp_rv, {tag_rd, " right rvalid (R3)"});
        chk(r_rdata,  exp_rd, {tag_rd, " right rdata"});
        master_mode = mode;
        l_en = lq.en; l_wr = lq.wr; l_oe = lq.oe; l_addr = lq.addr; l_wdata = lq.wdata;
        r_en = rq.en; r_wr = rq.wr; r_oe = rq.oe; r_addr = rq.addr; r_wdata = rq.wdata;
        l_busy_n_in = lbi; r_busy_n_in = rbi;
        #1;
        match = mode && lq.en && rq.en && (lq.addr == rq.addr);
        ls = ple && (pla == lq.addr);
        rs = pre && (pra == rq.addr);
        if (own != 0) win = own;
        else if (rs && !ls) win = 2;
        else win = 1;
        lbn = mode ? !(match && win == 2) : 1'b1;
        rbn = mode ? !(match && win == 1) : 1'b1;
        chk(l_busy_n_out, lbn, {tag_bz, " left busy_n_out"});
        chk(r_busy_n_out, rbn, {tag_bz, " right busy_n_out"});
        leff = mode ? lbn : lbi;
        reff = mode ? rbn : rbi;
        exp_lv = lq.en && !lq.wr && lq.oe;
        exp_ld = exp_lv ? m[lq.addr] : '0;
        exp_rv = rq.en && !rq.wr && rq.oe;
        exp_rd = exp_rv ? m[rq.addr] : '0;
        if (rq.en && rq.wr && reff) m[rq.addr] = rq.wdata;
        if (lq.en && lq.wr && leff) m[lq.addr] = lq.wdata;
        own = match ? win : 0;
        ple = lq.en; pla = lq.addr;
        pre = rq.en; pra = rq.addr;
    endtask

    function automatic port_req_t idle_q();
        return mk(0, 0, 0, '0, '0);
    endfunction

    function automatic port_req_t rd(input addr_t a);
        return mk(1, 0, 1, a, '0);
    endfunction

    function automatic port_req_t wrq(input addr_t a, input word_t d);
        return mk(1, 1, 0, a, d);
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h1d2c3b4a));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R12: reset state
        chk(l_rvalid, 0, "R12 left rvalid after reset");
        chk(r_rvalid, 0, "R12 right rvalid after reset");
        chk(l_rdata, 0, "R12 left rdata after reset");
        chk(r_busy_n_out, 1, "R12 right busy_n_out after reset");

        // R2: fill every word from the left port in slave mode
        tag_rd = "R2"; tag_bz = "R8";
        for (int a = 0; a < int'(DEPTH); a++)
            step(0, wrq(addr_t'(a), word_t'((a * 7 + 3) ^ (a >> 3))), idle_q(), 1, 1);

        // R7: left incumbent, right newcomer writes and is dropped (R5)
        tag_rd = "R7"; tag_bz = "R7";
        step(1, rd(5), idle_q(), 1, 1);
        step(1, rd(5), wrq(5, 8'h77), 1, 1);
        step(1, rd(5), wrq(5, 8'h78), 1, 1);
        tag_rd = "R5";
        step(1, idle_q(), rd(5), 1, 1);

        // R7: right incumbent, left newcomer loses; its read still works (R5)
        tag_rd = "R7"; tag_bz = "R7";
        step(1, idle_q(), rd(9), 1, 1);
        step(1, wrq(9, 8'h11), rd(9), 1, 1);
        step(1, rd(9), rd(9), 1, 1);
        tag_rd = "R5";
        step(1, idle_q(), rd(9), 1, 1);

        // R7 simultaneous arrival: left wins; R10 loser reads old value
        tag_rd = "R10"; tag_bz = "R7";
        step(1, wrq(12, 8'hA5), rd(12), 1, 1);
        step(1, idle_q(), idle_q(), 1, 1);
        step(1, rd(12), rd(12), 1, 1);
        step(1, idle_q(), idle_q(), 1, 1);

        // R9: busy inputs low have no effect in master mode; R1 different words
        tag_rd = "R9"; tag_bz = "R9";
        step(1, wrq(100, 8'h3E), wrq(101, 8'hC1), 0, 0);
        tag_rd = "R1";
        step(1, rd(101), rd(100), 0, 0);
        step(1, idle_q(), idle_q(), 1, 1);

        // R8: slave mode, left busy input low drops the write, read continues (R5)
        tag_rd = "R8"; tag_bz = "R8";
        step(0, wrq(20, 8'h3C), wrq(21, 8'h4D), 0, 1);
        step(0, rd(20), rd(21), 0, 1);
        tag_rd = "R5";
        step(0, rd(20), idle_q(), 0, 0);
        step(0, idle_q(), idle_q(), 1, 1);

        // R11: slave double write, left data survives
        tag_rd = "R11";
        step(0, wrq(30, 8'h5A), wrq(30, 8'hA5), 1, 1);
        step(0, idle_q(), rd(30), 1, 1);
        step(0, idle_q(), idle_q(), 1, 1);

        // R4: disabled port ignores controls and does not cause a match
        tag_rd = "R4"; tag_bz = "R4";
        step(1, mk(0, 1, 1, 40, 8'hEE), wrq(40, 8'h66), 1, 1);
        step(1, mk(0, 0, 1, 40, 8'h00), rd(40), 1, 1);
        step(1, rd(40), idle_q(), 1, 1);
        step(1, idle_q(), idle_q(), 1, 1);

        // R3: oe low gives no read data
        tag_rd = "R3"; tag_bz = "R6";
        step(1, mk(1, 0, 0, 40, 0), mk(1, 0, 0, 41, 0), 1, 1);
        step(1, idle_q(), idle_q(), 1, 1);

        // R1/R6 random mix on a small address pool
        tag_rd = "R1"; tag_bz = "R6";
        for (int i = 0; i < 4000; i++) begin
            bit md;
            port_req_t lq, rq;
            md = ($urandom % 4) != 0;
            lq = mk($urandom % 4 != 0, $urandom % 2, $urandom % 4 != 0,
                    addr_t'(($urandom % 8 == 0) ? $urandom : $urandom % 6), word_t'($urandom));
            rq = mk($urandom % 4 != 0, $urandom % 2, $urandom % 4 != 0,
                    addr_t'(($urandom % 8 == 0) ? $urandom : $urandom % 6), word_t'($urandom));
            tag_bz = md ? "R6" : "R8";
            step(md, lq, rq, $urandom % 3 != 0, $urandom % 3 != 0);
        end
        step(1, idle_q(), idle_q(), 1, 1);
        step(1, idle_q(), idle_q(), 1, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule